// File: doc/BRIEF.md
# Token-Passing Vector Broadcast Bus

This block arbitrates one shared data bus among a group of processing elements. Each element owns one slice of an iteration vector, and every element needs the whole vector each iteration. A single token circulates among the elements, and only the element that holds it may drive the bus. The holder streams its whole local slice, one word per cycle, with a word strobe and a last-word strobe. Every other element writes each word into its own receive region. The write address there is the sender's index times the slice length plus the word offset, so a component's index is its address and no index is stored.

An iteration starts with a start pulse. The token then visits elements 0 to C-1 in order, with no idle cycle between tenures. One cycle after the last element's final word, a one-cycle iteration-done pulse appears and the bus goes idle until the next start. Each element therefore sends N/C words and takes in the (C-1)·N/C words it does not own. The receive region of each element can be read combinationally by the downstream arithmetic.

Top module: `vbcast_bus`

## Requirements
- R1: Out of reset, `bus_grant` is 0, `bus_valid`, `bus_last` and `iter_done` are 0, and every word of every receive region reads 0.
- R2: A `start` sampled high while idle puts the bus in use from the next cycle, granted to element 0 at word offset 0.
- R3: While `bus_valid` is high, `bus_grant` has exactly one bit set, and that bit is bit `bus_src`. While `bus_valid` is low, `bus_grant` is 0.
- R4: A tenure lasts exactly SLICE_LEN cycles. `src_off` steps 0,1,…,SLICE_LEN-1, and `bus_last` is high only on offset SLICE_LEN-1. `bus_data` equals the word that the holder presents on its lane of `loc_data`, where lane p is bits [p*DATA_W +: DATA_W].
- R5: After a last word from element k < C-1, element k+1 holds the bus in the very next cycle at offset 0.
- R6: Each word driven by element s at offset o is stored in every other element's receive region at address s*SLICE_LEN+o.
- R7: An element never writes its own broadcast into its receive region. Addresses p*SLICE_LEN to p*SLICE_LEN+SLICE_LEN-1 of element p keep their reset value 0.
- R8: `iter_done` is high for exactly one cycle, in the cycle after element C-1's last word. After that, `bus_valid` stays 0 until a new `start`.
- R9: A `start` pulse while the bus is in use is ignored: the order and length of that iteration are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one broadcast round |
| loc_data | input | NUM_PE*DATA_W | Per-element lane holding the word at `src_off` of its own slice |
| src_off | output | OFF_W | Word offset within the holder's slice |
| bus_grant | output | NUM_PE | One-hot grant to the token holder |
| bus_src | output | PE_W | Index of the token holder |
| bus_valid | output | 1 | Word strobe |
| bus_last | output | 1 | Last word of the holder's slice |
| bus_data | output | DATA_W | Broadcast word |
| iter_done | output | 1 | One-cycle pulse once all elements have broadcast |
| rd_pe | input | PE_W | Element whose receive region is read |
| rd_addr | input | ADDR_W | Address within that receive region |
| rd_data | output | DATA_W | Receive-region word (combinational) |

## Verification
The bench runs two full rounds, each with a distinct data pattern. Every cycle it compares the holder, offset, grant, last strobe and data against an arithmetic model. A design that skips or repeats a token hand-over, or inserts a gap cycle between tenures, fails the cycle-exact comparison. After each round, every address of every receive region is read back. A wrong address computation scatters words to the wrong places, and a missing self-exclusion overwrites the zero own region. A mid-round start pulse checks that a restart does not truncate a round. The done pulse is checked for its exact cycle and for a width of one cycle.

// File: rtl/vbb_pkg.sv
// Package: shared helpers for the vector broadcast bus.
// Assumes: widths of at least one bit for every index.
package vbb_pkg;
    // Index width that stays at least 1 for a count of 1.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vbb_token_ring.sv
// Module: token ring sequencer. Holds the token index and word offset, walks
// elements 0..NUM_PE-1 with SLICE_LEN words each, then pulses done.
// Assumes: start is ignored while a round is running.
module vbb_token_ring
    import vbb_pkg::*;
#(
    parameter int NUM_PE    = 4,
    parameter int SLICE_LEN = 4,
    localparam int PE_W  = idx_w(NUM_PE),
    localparam int OFF_W = idx_w(SLICE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              active,
    output logic [PE_W-1:0]   holder,
    output logic [OFF_W-1:0]  offset,
    output logic              last,
    output logic [NUM_PE-1:0] grant,
    output logic              done
);
    localparam logic [PE_W-1:0]  LAST_PE  = PE_W'(NUM_PE - 1);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SLICE_LEN - 1);

    // Last-word strobe of the current tenure.
    always_comb last = active && (offset == LAST_OFF);

    // One-hot grant decoded from the token index.
    always_comb begin
        grant = '0;
        for (int p = 0; p < NUM_PE; p++)
            if (active && (holder == PE_W'(p))) grant[p] = 1'b1;
    end

    // Token, offset and done sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            holder <= '0;
            offset <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    holder <= '0;
                    offset <= '0;
                end
            end else if (last) begin
                offset <= '0;
                if (holder == LAST_PE) begin
                    active <= 1'b0;
                    holder <= '0;
                    done   <= 1'b1;
                end else begin
                    holder <= holder + 1'b1;
                end
            end else begin
                offset <= offset + 1'b1;
            end
        end
    end

    // R3: exactly one grant while in use, none otherwise.
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ($countones(grant) == 1));
    assert_grant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (grant == '0));
    // R4: offset steps within a tenure, holder unchanged.
    assert_offset_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last) |=> (active && offset == $past(offset) + 1'b1
                               && holder == $past(holder)));
    // R5: token passes to the next element with no gap.
    assert_token_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (last && holder != LAST_PE) |=> (active && offset == '0
                                         && holder == $past(holder) + 1'b1));
    // R8: done follows the last element's last word.
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && holder == LAST_PE) |=> (done && !active));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a running round is not cut short or restarted.
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(last && holder == LAST_PE)) |=> active);
endmodule

// File: rtl/vbb_bus_drive.sv
// Module: bus driver. Selects the token holder's lane onto the shared bus.
// Assumes: loc_data lane p carries element p's word at the current offset.
module vbb_bus_drive
    import vbb_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int DATA_W = 16,
    localparam int PE_W = idx_w(NUM_PE)
) (
    input  logic                     active,
    input  logic [PE_W-1:0]          holder,
    input  logic [NUM_PE*DATA_W-1:0] loc_data,
    output logic [DATA_W-1:0]        bus_data
);
    // Holder lane select; bus is zero while idle.
    always_comb begin
        bus_data = '0;
        for (int p = 0; p < NUM_PE; p++)
            if (active && (holder == PE_W'(p)))
                bus_data = loc_data[p*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/vbb_rx_bank.sv
// Module: receive region of one element. Stores broadcast words at
// sender*SLICE_LEN + offset; its own sender slot is never written.
// Assumes: wr_en is already gated off for this element's own tenure.
module vbb_rx_bank
    import vbb_pkg::*;
#(
    parameter int NUM_PE    = 4,
    parameter int SLICE_LEN = 4,
    parameter int DATA_W    = 16,
    parameter int PE_ID     = 0,
    localparam int PE_W   = idx_w(NUM_PE),
    localparam int OFF_W  = idx_w(SLICE_LEN),
    localparam int DEPTH  = NUM_PE * SLICE_LEN,
    localparam int ADDR_W = idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PE_W-1:0]   wr_src,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_addr;

    // Component index maps straight to the address.
    always_comb wr_addr = ADDR_W'(wr_src) * ADDR_W'(SLICE_LEN) + ADDR_W'(wr_off);

    // Clear on reset, then capture broadcast words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Combinational read port.
    always_comb rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;

    // R7: this element's own broadcast never lands here.
    assert_no_self_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_src != PE_W'(PE_ID)));
endmodule

// File: rtl/vbcast_bus.sv
// Module: token-passing vector broadcast bus. Sequences one bus tenure per
// element, drives the holder's slice onto the bus and fills every other
// element's receive region.
// Assumes: each element presents its word at src_off on its loc_data lane.
module vbcast_bus
    import vbb_pkg::*;
#(
    parameter int NUM_PE    = 4,
    parameter int SLICE_LEN = 4,
    parameter int DATA_W    = 16,
    localparam int PE_W   = idx_w(NUM_PE),
    localparam int OFF_W  = idx_w(SLICE_LEN),
    localparam int ADDR_W = idx_w(NUM_PE * SLICE_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NUM_PE*DATA_W-1:0] loc_data,
    output logic [OFF_W-1:0]         src_off,
    output logic [NUM_PE-1:0]        bus_grant,
    output logic [PE_W-1:0]          bus_src,
    output logic                     bus_valid,
    output logic                     bus_last,
    output logic [DATA_W-1:0]        bus_data,
    output logic                     iter_done,
    input  logic [PE_W-1:0]          rd_pe,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] bank_rd [NUM_PE];

    vbb_token_ring #(.NUM_PE(NUM_PE), .SLICE_LEN(SLICE_LEN)) i_ring (
        .clk(clk), .rst_n(rst_n), .start(start),
        .active(bus_valid), .holder(bus_src), .offset(src_off),
        .last(bus_last), .grant(bus_grant), .done(iter_done)
    );

    vbb_bus_drive #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) i_drive (
        .active(bus_valid), .holder(bus_src),
        .loc_data(loc_data), .bus_data(bus_data)
    );

    // One receive region per element; writes gated off by its grant.
    for (genvar g = 0; g < NUM_PE; g++) begin : g_rx
        vbb_rx_bank #(.NUM_PE(NUM_PE), .SLICE_LEN(SLICE_LEN),
                      .DATA_W(DATA_W), .PE_ID(g)) i_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_valid && !bus_grant[g]),
            .wr_src(bus_src), .wr_off(src_off), .wr_data(bus_data),
            .rd_addr(rd_addr), .rd_data(bank_rd[g])
        );
    end

    // Read-back select across elements.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PE; p++)
            if (rd_pe == PE_W'(p)) rd_data = bank_rd[p];
    end

    // R2: a round opens with element 0 at offset 0.
    assert_round_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && start) |=> (bus_valid && bus_src == '0 && src_off == '0));
endmodule

// File: tb/test_vbcast_bus.sv
module test_vbcast_bus;
    localparam int NPE = 4;
    localparam int SL  = 4;
    localparam int DW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NPE*DW-1:0] loc_data;
    logic [1:0] src_off;
    logic [NPE-1:0] bus_grant;
    logic [1:0] bus_src;
    logic bus_valid, bus_last, iter_done;
    logic [DW-1:0] bus_data;
    logic [1:0] rd_pe = '0;
    logic [3:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    int unsigned tag = 0;
    int compared = 0;
    int mismatched = 0;

    vbcast_bus #(.NUM_PE(NPE), .SLICE_LEN(SL), .DATA_W(DW)) i_vbcast_bus (
        .clk(clk), .rst_n(rst_n), .start(start), .loc_data(loc_data),
        .src_off(src_off), .bus_grant(bus_grant), .bus_src(bus_src),
        .bus_valid(bus_valid), .bus_last(bus_last), .bus_data(bus_data),
        .iter_done(iter_done), .rd_pe(rd_pe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] word_of(int t, int p, int o);
        return DW'(t * 256 + p * 16 + o + 1);
    endfunction

    // Each element presents its slice word at the requested offset.
    always_comb
        for (int p = 0; p < NPE; p++)
            loc_data[p*DW +: DW] = word_of(int'(tag), p, int'(src_off));

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_banks(input int t, input string req);
        for (int p = 0; p < NPE; p++)
            for (int a = 0; a < NPE*SL; a++) begin
                rd_pe = 2'(p);
                rd_addr = 4'(a);
                #1;
                if (a / SL == p) chk("R7 own region", int'(rd_data), 0);
                else chk(req, int'(rd_data), (t < 0) ? 0 : int'(word_of(t, a / SL, a % SL)));
            end
    endtask

    task automatic run_round(input int t, input bit poke_start);
        tag = t;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int p = 0; p < NPE; p++)
            for (int o = 0; o < SL; o++) begin
                if (poke_start && p == 1 && o == 2) start = 1'b1;  // R9
                else start = 1'b0;
                #1;
                chk("R2/R5 valid", int'(bus_valid), 1);
                chk("R5 holder", int'(bus_src), p);
                chk("R4 offset", int'(src_off), o);
                chk("R3 grant", int'(bus_grant), 1 << p);
                chk("R4 last", int'(bus_last), (o == SL-1) ? 1 : 0);
                chk("R4 data", int'(bus_data), int'(word_of(t, p, o)));
                chk("R8 done low", int'(iter_done), 0);
                @(negedge clk);
            end
        start = 1'b0;
        chk("R8 done pulse", int'(iter_done), 1);
        chk("R8 idle", int'(bus_valid), 0);
        chk("R3 grant idle", int'(bus_grant), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 done width", int'(iter_done), 0);
            chk("R8 stays idle", int'(bus_valid), 0);
        end
        check_banks(t, "R6 rx content");
    endtask

    initial begin
        #200000;
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 grant", int'(bus_grant), 0);
        chk("R1 valid", int'(bus_valid), 0);
        chk("R1 last", int'(bus_last), 0);
        chk("R1 done", int'(iter_done), 0);
        check_banks(-1, "R1 rx clear");
        run_round(1, 1'b0);
        run_round(2, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule